// File: doc/BRIEF.md
# Serial Receive Queue and Interrupt Register Front End

This block sits between the byte side of a serial receiver and a 32-bit register bus. Incoming bytes are kept in a 16-entry circular queue. Software sees the oldest byte through a status/data word that it can read at two addresses. A read at the "look" address leaves the queue unchanged. A read at the "take" address also removes the byte. The same word carries a data-present flag and two transmitter flags that always read as 1. Writing the transmit register sends its low byte out as a one-cycle strobe.

An interrupt status register has two latched transmit bits and one receive bit. The receive bit follows the queue occupancy and is not latched. The status is ANDed with a mask register and reduced onto one interrupt line. An acknowledge register clears status bits with write-one-to-clear. The first acknowledge after a transmit write always keeps bit 0 set.

Bytes arrive on a valid/ready stream. A byte is taken only in a cycle where both `rx_valid` and `rx_ready` are high. While `rx_ready` is low the producer must hold its byte. A byte that is offered and then withdrawn while `rx_ready` is low is never stored. The free-space count `rx_space` is also output, so an upstream flow-control stage can use it.

Top module: `uart_rx_regfront`

## Requirements
- R1: After reset the queue is empty, and the interrupt status, mask, receive-control and pending-transmit state are all 0. `irq` and `tx_strobe` are low.
- R2: The status/data word has this layout:
  - bit 8 is 1 exactly when the queue is non-empty;
  - bits 10:9 always read as 1;
  - bits 31:11 read as 0;
  - bits 7:0 hold the oldest byte whenever bit 8 is 1.
- R3: A read at word address 2 returns the status/data word and changes nothing. A read at word address 3 returns the same word, then removes the oldest byte if the queue is non-empty. A read at address 3 on an empty queue removes nothing.
- R4: Bytes leave in the order they arrived. This holds for up to 16 stored bytes and across wrap-around of the write position.
- R5: `rx_ready` is high only when bit 3 of the receive-control register (word address 1) is set and fewer than 16 bytes are stored. A byte offered while `rx_ready` is low is not stored.
- R6: `rx_space` equals 16 minus the occupancy while bit 3 of receive control is set. Otherwise it is 0.
- R7: A take-read and an accepted byte in the same cycle leave the occupancy unchanged. The read returns the old head.
- R8: A write to word address 0 produces `tx_strobe` for exactly the next cycle, with `tx_byte` equal to the written bits 7:0. It also sets interrupt status bits 0 and 1 and sets pending-transmit.
- R9: A write to word address 7 clears each interrupt status bit that is written as 1. If pending-transmit is set, bit 0 of the written value is treated as 0 and pending-transmit is cleared.
- R10: Interrupt status bit 3 (read at word address 4) is 1 exactly while the queue is non-empty. An acknowledge cannot clear it.
- R11: Word address 6 reads the interrupt status ANDed with the mask (word address 5). `irq` is high when that result is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle as the read strobe |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Queue can accept a byte |
| rx_space | output | 5 | Free entries for flow control |
| tx_strobe | output | 1 | One-cycle transmit pulse |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Interrupt request |

## Verification
A wrong occupancy count shows at the ports in the same cycle. It appears as a wrong `rx_space`, a wrong data-present bit, or interrupt status bit 3 disagreeing with the data-present bit. A corrupted read position shows as a byte returned out of arrival order. This is visible at the first take-read after a wrap. A stuck pending-transmit flag shows on the first acknowledge after a transmit write: bit 0 of the status clears when it should stay set, or stays set when it should clear.

// File: rtl/urf_pkg.sv
package urf_pkg;
  localparam int URF_A_TX     = 0;
  localparam int URF_A_RXCTL  = 1;
  localparam int URF_A_LOOK   = 2;
  localparam int URF_A_TAKE   = 3;
  localparam int URF_A_ISTAT  = 4;
  localparam int URF_A_IMASK  = 5;
  localparam int URF_A_IMSKD  = 6;
  localparam int URF_A_ACK    = 7;

  localparam int URF_DAV_BIT  = 8;
  localparam int URF_TRDY_BIT = 9;
  localparam int URF_TIDL_BIT = 10;
  localparam int URF_RXEN_BIT = 3;

  localparam int URF_INT_W    = 4;
  localparam int URF_INT_RX   = 3;
endpackage

// File: rtl/urf_fifo.sv
module urf_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_pos;
  logic [PW-1:0] rd_idx;
  logic          full, empty, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  // oldest slot: write position minus occupancy, modulo depth
  assign rd_idx  = wr_pos - count[PW-1:0];
  assign head    = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pos <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wr_pos] <= push_data;
        wr_pos      <= wr_pos + 1'b1;
      end
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/urf_irq.sv
module urf_irq #(
  parameter int INT_W  = 4,
  parameter int RX_BIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_fire,
  input  logic             ack_we,
  input  logic [INT_W-1:0] ack_val,
  input  logic             mask_we,
  input  logic [INT_W-1:0] mask_val,
  input  logic             rx_nonempty,
  output logic [INT_W-1:0] stat,
  output logic [INT_W-1:0] mask,
  output logic [INT_W-1:0] masked,
  output logic             irq
);
  localparam logic [INT_W-1:0] TX_BITS = INT_W'(3);
  localparam logic [INT_W-1:0] RX_MSK  = INT_W'(1) << RX_BIT;

  logic [INT_W-1:0] lat;
  logic             pend_tx;
  logic [INT_W-1:0] ack_eff;

  always_comb begin
    stat         = lat;
    stat[RX_BIT] = rx_nonempty;
    ack_eff      = ack_val;
    if (pend_tx) ack_eff[0] = 1'b0;
  end

  assign masked = stat & mask;
  assign irq    = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat     <= '0;
      pend_tx <= 1'b0;
      mask    <= '0;
    end else begin
      if (mask_we) mask <= mask_val;
      if (tx_fire) begin
        lat     <= (lat | TX_BITS) & ~RX_MSK;
        pend_tx <= 1'b1;
      end else if (ack_we) begin
        lat     <= lat & ~ack_eff & ~RX_MSK;
        pend_tx <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_rx_regfront.sv
module uart_rx_regfront
  import urf_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic [CW-1:0]     rx_space,
  output logic              tx_strobe,
  output logic [7:0]        tx_byte,
  output logic              irq
);
  logic [31:0]          rxctl;
  logic [7:0]           head;
  logic [CW-1:0]        fifo_cnt;
  logic [URF_INT_W-1:0] int_stat, int_mask, int_mskd;
  logic                 rx_en, nonempty, take, hit_tx;
  logic [31:0]          stat_word;

  assign rx_en    = rxctl[URF_RXEN_BIT];
  assign nonempty = (fifo_cnt != '0);
  assign rx_space = rx_en ? CW'(DEPTH) - fifo_cnt : '0;
  assign rx_ready = (rx_space != '0);
  assign take     = reg_re && (reg_addr == ADDR_W'(URF_A_TAKE));
  assign hit_tx   = reg_we && (reg_addr == ADDR_W'(URF_A_TX));

  urf_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(rx_valid && rx_ready), .push_data(rx_data),
    .pop(take), .head(head), .count(fifo_cnt)
  );

  urf_irq #(.INT_W(URF_INT_W), .RX_BIT(URF_INT_RX)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .tx_fire(hit_tx),
    .ack_we(reg_we && (reg_addr == ADDR_W'(URF_A_ACK))),
    .ack_val(reg_wdata[URF_INT_W-1:0]),
    .mask_we(reg_we && (reg_addr == ADDR_W'(URF_A_IMASK))),
    .mask_val(reg_wdata[URF_INT_W-1:0]),
    .rx_nonempty(nonempty),
    .stat(int_stat), .mask(int_mask), .masked(int_mskd), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxctl     <= '0;
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      tx_strobe <= hit_tx;
      if (hit_tx) tx_byte <= reg_wdata[7:0];
      if (reg_we && (reg_addr == ADDR_W'(URF_A_RXCTL))) rxctl <= reg_wdata;
    end
  end

  always_comb begin
    stat_word               = {24'h0, head};
    stat_word[URF_DAV_BIT]  = nonempty;
    stat_word[URF_TRDY_BIT] = 1'b1;
    stat_word[URF_TIDL_BIT] = 1'b1;
    case (int'(reg_addr))
      URF_A_RXCTL:             reg_rdata = rxctl;
      URF_A_LOOK, URF_A_TAKE:  reg_rdata = stat_word;
      URF_A_ISTAT:             reg_rdata = 32'(int_stat);
      URF_A_IMASK:             reg_rdata = 32'(int_mask);
      URF_A_IMSKD:             reg_rdata = 32'(int_mskd);
      default:                 reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/urf_checker.sv
module urf_checker
  import urf_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              reg_re,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_strobe,
  input logic [7:0]        tx_byte,
  input logic [CW-1:0]     fifo_cnt,
  input logic [3:0]        int_stat
);
  logic acc, take_rd, look_rd, txw;
  assign acc     = rx_valid && rx_ready;
  assign take_rd = reg_re && (reg_addr == ADDR_W'(URF_A_TAKE));
  assign look_rd = reg_re && (reg_addr == ADDR_W'(URF_A_LOOK));
  assign txw     = reg_we && (reg_addr == ADDR_W'(URF_A_TX));

  a_r2_word_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (look_rd || take_rd) |-> (reg_rdata[10:9] == 2'b11 && reg_rdata[8] == (fifo_cnt != '0)));
  a_r3_take_removes: assert property (@(posedge clk) disable iff (!rst_n)
    (take_rd && fifo_cnt != '0 && !acc) |=> (fifo_cnt + 1'b1 == $past(fifo_cnt)));
  a_r3_look_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (look_rd && !acc) |=> $stable(fifo_cnt));
  a_r5_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CW'(DEPTH)) |-> !rx_ready);
  a_r7_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && take_rd) |=> $stable(fifo_cnt));
  a_r8_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    txw |=> (tx_strobe && tx_byte == $past(reg_wdata[7:0])));
  a_r8_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
    !txw |=> !tx_strobe);
  a_r10_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
    int_stat[3] == (fifo_cnt != '0));
endmodule

bind uart_rx_regfront urf_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_strobe(tx_strobe),
  .tx_byte(tx_byte), .fifo_cnt(fifo_cnt), .int_stat(int_stat)
);

// File: tb/sim_uart_rx_regfront.sv
`timescale 1ns/1ps
module sim_uart_rx_regfront;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0, reg_re = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        rx_valid = 0;
  logic [7:0]  rx_data = 0;
  logic        rx_ready, tx_strobe, irq;
  logic [4:0]  rx_space;
  logic [7:0]  tx_byte;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_rx_regfront u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_re = 1; reg_addr = 3'(a);
    #1 d = reg_rdata;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic offer(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4, d); chk("R1 istat", d, 0);
    rd(5, d); chk("R1 mask", d, 0);
    rd(1, d); chk("R1 rxctl", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 strobe", tx_strobe, 0);
    chk("R6 space disabled", rx_space, 0);
    rd(2, d); chk("R2 empty word", d & 32'hFFFF_FF00, 32'h600);
  endtask

  task automatic t_basic;
    logic [31:0] d;
    wr(1, 32'h8);
    chk("R6 space enabled", rx_space, 16);
    offer(8'hA5); offer(8'h3C);
    chk("R6 space two", rx_space, 14);
    rd(2, d); chk("R2 look word", d, 32'h7A5);
    rd(2, d); chk("R3 look again", d, 32'h7A5);
    rd(3, d); chk("R3 take", d, 32'h7A5);
    chk("R3 space after take", rx_space, 15);
    rd(3, d); chk("R4 second byte", d[8:0], 9'h13C);
    rd(3, d); chk("R3 take empty dav", d[8], 0);
    chk("R3 take empty space", rx_space, 16);
  endtask

  task automatic t_fill;
    logic [31:0] d;
    for (int i = 0; i < 16; i++) offer(8'(i * 7 + 1));
    chk("R6 full space", rx_space, 0);
    chk("R5 full not ready", rx_ready, 0);
    offer(8'hEE);
    for (int i = 0; i < 16; i++) begin
      rd(3, d); chk("R4 order full", d[8:0], {1'b1, 8'(i * 7 + 1)});
    end
    rd(2, d); chk("R5 dropped byte absent", d[8], 0);
    for (int i = 0; i < 3; i++) offer(8'(8'hC0 + i));
    for (int i = 0; i < 3; i++) begin
      rd(3, d); chk("R4 order wrap", d[8:0], {1'b1, 8'(8'hC0 + i)});
    end
  endtask

  task automatic t_simul;
    logic [31:0] d;
    offer(8'h11); offer(8'h22);
    @(negedge clk); rx_valid = 1; rx_data = 8'h33; reg_re = 1; reg_addr = 3;
    #1 d = reg_rdata;
    @(negedge clk); rx_valid = 0; reg_re = 0;
    chk("R7 head returned", d[8:0], 9'h111);
    chk("R7 net zero", rx_space, 14);
    rd(3, d); chk("R7 order a", d[7:0], 8'h22);
    rd(3, d); chk("R7 order b", d[7:0], 8'h33);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    wr(1, 32'h7);
    chk("R6 disabled space", rx_space, 0);
    chk("R5 disabled ready", rx_ready, 0);
    offer(8'h5A);
    wr(1, 32'h8);
    rd(2, d); chk("R5 disabled not stored", d[8], 0);
  endtask

  task automatic t_intr;
    logic [31:0] d;
    wr(5, 32'h8);
    chk("R11 irq idle", irq, 0);
    offer(8'h42);
    rd(4, d); chk("R10 bit3 set", d, 32'h8);
    rd(6, d); chk("R11 masked", d, 32'h8);
    chk("R11 irq on", irq, 1);
    wr(7, 32'h8);
    rd(4, d); chk("R10 ack no effect", d, 32'h8);
    rd(3, d);
    rd(4, d); chk("R10 bit3 clear", d, 0);
    chk("R11 irq off", irq, 0);
  endtask

  task automatic t_tx;
    logic [31:0] d;
    wr(5, 32'h1);
    wr(0, 32'h1234_56C3);
    #1 chk("R8 strobe", tx_strobe, 1);
    chk("R8 byte", tx_byte, 8'hC3);
    @(negedge clk); #1 chk("R8 single pulse", tx_strobe, 0);
    rd(4, d); chk("R8 status bits", d, 32'h3);
    chk("R11 irq tx", irq, 1);
    wr(7, 32'h3);
    rd(4, d); chk("R9 bit0 kept", d, 32'h1);
    chk("R11 irq still", irq, 1);
    wr(7, 32'h1);
    rd(4, d); chk("R9 second ack clears", d, 0);
    chk("R11 irq cleared", irq, 0);
    wr(0, 32'h7E);
    wr(7, 32'h2);
    rd(4, d); chk("R9 pending eaten", d, 32'h1);
    wr(7, 32'h1);
    rd(4, d); chk("R9 plain ack", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_basic; t_fill; t_simul; t_disabled; t_intr; t_tx;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule